// File: doc/BRIEF.md
# Real-Time Clock Calendar with Alarm

This block keeps wall-clock time and date for a chip that has a slow crystal domain. A single-cycle enable, pulsed once per period of the 32.768 kHz reference, drives a prescaler. The prescaler's terminal count is the nominal divide value plus a signed trim, so a board can correct a crystal that runs fast or slow. At each one-second boundary, seconds, minutes and hours advance. Day, month and year follow, with month lengths and leap years handled in hardware. The hour count runs either 0 to 23 or 12, 1 to 11 with a PM marker.

An alarm holds a full copy of the six time fields. It fires only when every field, PM marker included, equals the current time just after a second has elapsed. Writing a time value directly does not fire it. Two sticky flags, one for the second tick and one for the alarm, are cleared by writing ones to them. Each flag has an enable that gates its interrupt output and a one-cycle wake-up pulse.

Software reaches the block through a flat byte-wide register port with a combinational read. All fields are plain binary.

Top module: `rtc_core`

## Requirements
- R1: Seconds and minutes each count 0 to 59; the wrap of seconds from 59 to 0 advances minutes, and the wrap of minutes advances hours.
- R2: With control bit 0 (address 12) clear, hours run 0 to 23; a tick at 23:59:59 gives 00:00:00 and advances the day.
- R3: With control bit 0 set, the hour register (address 2, hour in bits 4:0, PM in bit 5) runs 12, 1, ..., 11. PM toggles when 11 becomes 12. The day advances only on 11 PM to 12 AM.
- R4: Day (address 3) runs from 1 to 30 in months 4, 6, 9 and 11, and from 1 to 31 in the other months except February. Month (address 4) wraps from 12 to 1 and then advances the year (address 5). The year wraps from 99 to 0.
- R5: February has 29 days when the year value is a multiple of 4 and 28 days otherwise.
- R6: A second elapses after NOMINAL plus C enable pulses, where C is the signed 8-bit trim at address 13.
- R7: Writing any time field (addresses 0 to 5) restarts the prescaler, so the next second elapses a full period after the write.
- R8: The alarm flag (status bit 1, address 14) sets one cycle after a second elapses, and only if all six alarm fields (addresses 6 to 11, same layout as 0 to 5) equal the new time.
- R9: The tick flag (status bit 0) sets on every elapsed second. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An interrupt output is high while its flag is set and its enable is set (control bit 1 for the tick, bit 2 for the alarm).
- R10: The wake output pulses high for exactly one cycle, one cycle after a second elapses, if the tick enable is set, or if the alarm enable is set and the alarm matches; otherwise it stays low.
- R11: After reset the time reads 00:00:00, day 1, month 1, year 0, with both flags clear and wake low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | One pulse per reference-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tick_irq | output | 1 | Tick flag AND tick enable |
| alarm_irq | output | 1 | Alarm flag AND alarm enable |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The bench targets the cascade boundaries: 23:59:59, 30- and 31-day month ends, Feb 28 and Feb 29 in leap and non-leap years, and the year 99 wrap. A wrong carry chain would land on an impossible date or skip a day. In 12-hour mode it checks both 11 to 12 transitions and 12 to 1. A design that toggled PM or advanced the day at the wrong one would read back a mislabeled half-day or a wrong date. The prescaler is timed one pulse before and at the expected edge for positive, zero and negative trim, and again after a mid-second rewrite; a missing restart or a sign error shifts the tick. The alarm is tested with a full match and with one field off, so a partial compare would raise a false flag or a false wake. Write-zero and write-other-bit cases expose a flag clear that ignores the mask.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC      = 4'd0,
        RA_MIN      = 4'd1,
        RA_HOUR     = 4'd2,
        RA_DAY      = 4'd3,
        RA_MON      = 4'd4,
        RA_YEAR     = 4'd5,
        RA_AL_SEC   = 4'd6,
        RA_AL_MIN   = 4'd7,
        RA_AL_HOUR  = 4'd8,
        RA_AL_DAY   = 4'd9,
        RA_AL_MON   = 4'd10,
        RA_AL_YEAR  = 4'd11,
        RA_CTRL     = 4'd12,
        RA_TRIM     = 4'd13,
        RA_STATUS   = 4'd14
    } reg_addr_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic       pm;
        logic [4:0] hr;
        logic [4:0] day;
        logic [3:0] mon;
        logic [6:0] yr;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{sec: 6'd0, min: 6'd0, pm: 1'b0, hr: 5'd0,
                                         day: 5'd1, mon: 4'd1, yr: 7'd0};

    function automatic logic is_leap(input logic [6:0] yr);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      return is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic rtc_time_t put_field(input rtc_time_t t, input logic [2:0] idx,
                                            input logic [DATA_W-1:0] d);
        rtc_time_t r;
        r = t;
        case (idx)
            3'd0:    r.sec = d[5:0];
            3'd1:    r.min = d[5:0];
            3'd2:    begin r.hr = d[4:0]; r.pm = d[5]; end
            3'd3:    r.day = d[4:0];
            3'd4:    r.mon = d[3:0];
            3'd5:    r.yr  = d[6:0];
            default: r = t;
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] take_field(input rtc_time_t t, input logic [2:0] idx);
        case (idx)
            3'd0:    return {2'b00, t.sec};
            3'd1:    return {2'b00, t.min};
            3'd2:    return {2'b00, t.pm, t.hr};
            3'd3:    return {3'b000, t.day};
            3'd4:    return {4'b0000, t.mon};
            3'd5:    return {1'b0, t.yr};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int NOMINAL = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xtal_en,
    input  logic       restart,
    input  logic [7:0] trim,
    output logic       sec_strobe
);
    localparam int CW = $clog2(NOMINAL + 128) + 1;
    localparam logic [CW-1:0] BASE = CW'(NOMINAL - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit      = BASE + {{(CW-8){trim[7]}}, trim};
    assign sec_strobe = xtal_en && !restart && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (xtal_en) begin
            cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
        end
    end

    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)); // R7

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mode12,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output rtc_time_t         now
);
    rtc_time_t cur;
    rtc_time_t nxt;
    logic      day_carry;

    always_comb begin
        nxt       = cur;
        day_carry = 1'b0;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (cur.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (mode12) begin
                    if (cur.hr == 5'd11) begin
                        nxt.hr    = 5'd12;
                        nxt.pm    = ~cur.pm;
                        day_carry = cur.pm;
                    end else if (cur.hr >= 5'd12) begin
                        nxt.hr = 5'd1;
                    end else begin
                        nxt.hr = cur.hr + 5'd1;
                    end
                end else if (cur.hr >= 5'd23) begin
                    nxt.hr    = 5'd0;
                    day_carry = 1'b1;
                end else begin
                    nxt.hr = cur.hr + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end

        if (day_carry) begin
            if (cur.day >= month_len(cur.mon, cur.yr)) begin
                nxt.day = 5'd1;
                if (cur.mon >= 4'd12) begin
                    nxt.mon = 4'd1;
                    nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
                end else begin
                    nxt.mon = cur.mon + 4'd1;
                end
            end else begin
                nxt.day = cur.day + 5'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= TIME_RESET;
        end else if (wr_en) begin
            cur <= put_field(cur, wr_idx, wr_data);
        end else if (tick) begin
            cur <= nxt;
        end
    end

    assign now = cur;

    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cur.sec == 6'd59 && cur.min < 6'd59)
        |=> (cur.sec == 6'd0 && cur.min == $past(cur.min) + 6'd1)); // R1

    AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && !mode12 && cur.hr == 5'd23 && cur.min == 6'd59 && cur.sec == 6'd59)
        |=> (cur.hr == 5'd0 && cur.min == 6'd0)); // R2

    AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && mode12 && cur.min == 6'd59 && cur.sec == 6'd59)
        |=> (cur.hr >= 5'd1 && cur.hr <= 5'd12)); // R3

    AST_DAY_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cur.day <= month_len(cur.mon, cur.yr))
        |=> (cur.day >= 5'd1 && cur.day <= month_len(cur.mon, cur.yr))); // R4

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  rtc_time_t         now,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        clr,
    input  logic              tick_ie,
    input  logic              alarm_ie,
    output rtc_time_t         alarm,
    output logic              tick_flag,
    output logic              alarm_flag,
    output logic              wake
);
    logic evt_q;
    logic match;

    assign match = (now == alarm);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm      <= TIME_RESET;
            evt_q      <= 1'b0;
            tick_flag  <= 1'b0;
            alarm_flag <= 1'b0;
            wake       <= 1'b0;
        end else begin
            evt_q <= tick;
            if (wr_en) begin
                alarm <= put_field(alarm, wr_idx, wr_data);
            end
            if (tick) begin
                tick_flag <= 1'b1;
            end else if (clr[0]) begin
                tick_flag <= 1'b0;
            end
            if (evt_q && match) begin
                alarm_flag <= 1'b1;
            end else if (clr[1]) begin
                alarm_flag <= 1'b0;
            end
            wake <= evt_q && (tick_ie || (alarm_ie && match));
        end
    end

    AST_ALARM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(match)); // R8

    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        tick |=> tick_flag); // R9

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake); // R10

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int NOMINAL = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xtal_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick_irq,
    output logic              alarm_irq,
    output logic              wake
);
    logic [2:0]  ctrl;
    logic [7:0]  trim;
    logic        time_wr;
    logic        alarm_wr;
    logic [2:0]  alarm_idx;
    logic [1:0]  clr;
    logic        sec_strobe;
    logic        tick_flag;
    logic        alarm_flag;
    rtc_time_t   now;
    rtc_time_t   alarm;

    assign time_wr   = wr_en && (wr_addr <= RA_YEAR);
    assign alarm_wr  = wr_en && (wr_addr >= RA_AL_SEC) && (wr_addr <= RA_AL_YEAR);
    assign alarm_idx = 3'(wr_addr - RA_AL_SEC);
    assign clr       = (wr_en && wr_addr == RA_STATUS) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            trim <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_CTRL) ctrl <= wr_data[2:0];
            if (wr_addr == RA_TRIM) trim <= wr_data;
        end
    end

    rtc_prescaler #(.NOMINAL(NOMINAL)) u_prescaler (
        .clk        (clk),
        .rst        (rst),
        .xtal_en    (xtal_en),
        .restart    (time_wr),
        .trim       (trim),
        .sec_strobe (sec_strobe)
    );

    rtc_counters u_counters (
        .clk     (clk),
        .rst     (rst),
        .tick    (sec_strobe),
        .mode12  (ctrl[0]),
        .wr_en   (time_wr),
        .wr_idx  (wr_addr[2:0]),
        .wr_data (wr_data),
        .now     (now)
    );

    rtc_alarm_irq u_alarm_irq (
        .clk        (clk),
        .rst        (rst),
        .tick       (sec_strobe),
        .now        (now),
        .wr_en      (alarm_wr),
        .wr_idx     (alarm_idx),
        .wr_data    (wr_data),
        .clr        (clr),
        .tick_ie    (ctrl[1]),
        .alarm_ie   (ctrl[2]),
        .alarm      (alarm),
        .tick_flag  (tick_flag),
        .alarm_flag (alarm_flag),
        .wake       (wake)
    );

    assign tick_irq  = tick_flag && ctrl[1];
    assign alarm_irq = alarm_flag && ctrl[2];

    always_comb begin
        if (rd_addr <= RA_YEAR) begin
            rd_data = take_field(now, rd_addr[2:0]);
        end else if (rd_addr <= RA_AL_YEAR) begin
            rd_data = take_field(alarm, 3'(rd_addr - RA_AL_SEC));
        end else begin
            case (rd_addr)
                RA_CTRL:   rd_data = {5'b0, ctrl};
                RA_TRIM:   rd_data = trim;
                RA_STATUS: rd_data = {6'b0, alarm_flag, tick_flag};
                default:   rd_data = '0;
            endcase
        end
    end

    AST_ALARM_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (alarm_flag && ctrl[2])); // R9

endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
    localparam int NOM = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xtal_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick_irq;
    logic       alarm_irq;
    logic       wake;

    int checks = 0;
    int errors = 0;
    int period = NOM;

    always #5 clk = ~clk;

    rtc_core #(.NOMINAL(NOM)) i_rtc_core (
        .clk(clk), .rst(rst), .xtal_en(xtal_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_irq(tick_irq), .alarm_irq(alarm_irq), .wake(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        xtal_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 xtal_en = 1'b0;
    endtask

    task automatic set_time(input int h, input int m, input int s,
                            input int d, input int mo, input int y);
        wr(4'd5, 8'(y)); wr(4'd4, 8'(mo)); wr(4'd3, 8'(d));
        wr(4'd2, 8'(h)); wr(4'd1, 8'(m)); wr(4'd0, 8'(s));
    endtask

    task automatic expect_time(input string req, input int h, input int m, input int s,
                               input int d, input int mo, input int y);
        int v;
        rd(4'd2, v); chk({req, " hour"}, v, h);
        rd(4'd1, v); chk({req, " min"}, v, m);
        rd(4'd0, v); chk({req, " sec"}, v, s);
        rd(4'd3, v); chk({req, " day"}, v, d);
        rd(4'd4, v); chk({req, " month"}, v, mo);
        rd(4'd5, v); chk({req, " year"}, v, y);
    endtask

    task automatic test_reset();
        int v;
        expect_time("R11", 0, 0, 0, 1, 1, 0);
        rd(4'd14, v); chk("R11 status", v, 0);
        chk("R11 wake", int'(wake), 0);
    endtask

    task automatic test_prescale();
        int v;
        period = NOM;
        wr(4'd0, 8'd10); run(period - 1);
        rd(4'd0, v); chk("R6 trim0 early", v, 10);
        run(1); rd(4'd0, v); chk("R6 trim0 tick", v, 11);
        wr(4'd13, 8'd5); period = NOM + 5;
        wr(4'd0, 8'd20); run(period - 1);
        rd(4'd0, v); chk("R6 trim+5 early", v, 20);
        run(1); rd(4'd0, v); chk("R6 trim+5 tick", v, 21);
        wr(4'd13, 8'hFD); period = NOM - 3;
        wr(4'd0, 8'd30); run(period - 1);
        rd(4'd0, v); chk("R6 trim-3 early", v, 30);
        run(1); rd(4'd0, v); chk("R6 trim-3 tick", v, 31);
        wr(4'd13, 8'd0); period = NOM;
    endtask

    task automatic test_restart();
        int v;
        wr(4'd0, 8'd5); run(7);
        wr(4'd0, 8'd40); run(period - 1);
        rd(4'd0, v); chk("R7 no early tick", v, 40);
        run(1); rd(4'd0, v); chk("R7 full period", v, 41);
    endtask

    task automatic test_24h();
        set_time(10, 59, 59, 5, 3, 7); run(period);
        expect_time("R1", 11, 0, 0, 5, 3, 7);
        set_time(23, 59, 59, 5, 3, 7); run(period);
        expect_time("R2", 0, 0, 0, 6, 3, 7);
    endtask

    task automatic test_calendar();
        set_time(23, 59, 59, 30, 4, 10); run(period);
        expect_time("R4 april end", 0, 0, 0, 1, 5, 10);
        set_time(23, 59, 59, 30, 5, 10); run(period);
        expect_time("R4 may 30", 0, 0, 0, 31, 5, 10);
        set_time(23, 59, 59, 31, 12, 99); run(period);
        expect_time("R4 year wrap", 0, 0, 0, 1, 1, 0);
        set_time(23, 59, 59, 28, 2, 24); run(period);
        expect_time("R5 leap feb28", 0, 0, 0, 29, 2, 24);
        set_time(23, 59, 59, 28, 2, 23); run(period);
        expect_time("R5 common feb28", 0, 0, 0, 1, 3, 23);
    endtask

    task automatic test_12h();
        wr(4'd12, 8'h01);
        set_time(11, 59, 59, 3, 6, 5); run(period);
        expect_time("R3 noon", 8'h2C, 0, 0, 3, 6, 5);
        set_time(8'h2C, 59, 59, 3, 6, 5); run(period);
        expect_time("R3 one pm", 8'h21, 0, 0, 3, 6, 5);
        set_time(8'h2B, 59, 59, 3, 6, 5); run(period);
        expect_time("R3 midnight", 8'h0C, 0, 0, 4, 6, 5);
        wr(4'd12, 8'h00);
    endtask

    task automatic test_flags();
        int v;
        wr(4'd12, 8'h02); wr(4'd14, 8'h03);
        wr(4'd0, 8'd0); run(period);
        rd(4'd14, v); chk("R9 tick flag set", v, 1);
        chk("R9 tick irq", int'(tick_irq), 1);
        @(posedge clk); #1 chk("R10 tick wake", int'(wake), 1);
        @(posedge clk); #1 chk("R10 wake one cycle", int'(wake), 0);
        wr(4'd14, 8'h00); rd(4'd14, v); chk("R9 write zero keeps", v, 1);
        wr(4'd14, 8'h02); rd(4'd14, v); chk("R9 other bit keeps", v, 1);
        wr(4'd14, 8'h01); rd(4'd14, v); chk("R9 w1c clears", v, 0);
        chk("R9 tick irq low", int'(tick_irq), 0);
    endtask

    task automatic test_alarm();
        int v;
        int seen;
        wr(4'd6, 8'd0); wr(4'd7, 8'd0); wr(4'd8, 8'd0);
        wr(4'd9, 8'd1); wr(4'd10, 8'd3); wr(4'd11, 8'd24);
        wr(4'd12, 8'h04); wr(4'd14, 8'h03);
        set_time(23, 59, 59, 29, 2, 24); run(period);
        expect_time("R5 leap feb29", 0, 0, 0, 1, 3, 24);
        rd(4'd14, v); chk("R8 not before eval", v, 1);
        @(posedge clk); #1;
        rd(4'd14, v); chk("R8 alarm match", v, 3);
        chk("R8 alarm irq", int'(alarm_irq), 1);
        chk("R10 alarm wake", int'(wake), 1);
        wr(4'd11, 8'd25); wr(4'd14, 8'h03);
        set_time(23, 59, 59, 29, 2, 24);
        seen = 0;
        @(negedge clk); xtal_en = 1'b1;
        repeat (period) @(posedge clk);
        #1 xtal_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (wake) seen = 1;
            @(posedge clk); #1;
        end
        rd(4'd14, v); chk("R8 year mismatch", v, 1);
        chk("R10 no wake on mismatch", seen, 0);
        wr(4'd12, 8'h00); wr(4'd14, 8'h03);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_prescale();
        test_restart();
        test_24h();
        test_calendar();
        test_12h();
        test_flags();
        test_alarm();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule